// File: doc/BRIEF.md
# Mode-Selectable Two-Bit Sequencer

This block is a synchronous state machine holding a two-bit state, presented on two outputs as bit A (high bit) and bit B (low bit). Two enable inputs must both be high for the state to move on a clock edge. When either enable is low, the state holds.

A third input picks one of two cyclic orders. With the selector low, the machine walks through all four codes. With the selector high, it walks a three-code loop. The code left out of that loop is steered back to zero.

A flag output reports whether the present state belongs to the loop that the selector currently picks. Typical use is as a small programmable step generator whose pace is gated by two independent qualifiers.

Top module: `seq2_stepper`

## Requirements
- R1: A synchronous active-high `rst` forces the state {A,B} to 00 at the next rising edge, whatever the other inputs are.
- R2: When `step_en_a` or `step_en_b` is 0, the state keeps its value across the edge, for either value of `order_sel`.
- R3: With both enables at 1 and `order_sel`=0, each edge moves {A,B} (A = `state_a`, B = `state_b`) along 00 → 11 → 10 → 01 → 00.
- R4: With both enables at 1 and `order_sel`=1, each edge moves {A,B} along 00 → 10 → 01 → 00.
- R5: With both enables at 1 and `order_sel`=1, the state 11 is followed by 00.
- R6: A change of `order_sel` between steps takes effect at the next edge, which follows the newly chosen order starting from the present state.
- R7: `in_cycle` is 1 for every state while `order_sel`=0. While `order_sel`=1 it is 0 in state 11 and 1 in all other states. It reflects the present state and the present `order_sel`.
- R8: The state outputs change only at a rising clock edge. Input changes between edges leave them unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to state 00 |
| step_en_a | input | 1 | First step qualifier |
| step_en_b | input | 1 | Second step qualifier |
| order_sel | input | 1 | 0 selects the four-state order, 1 selects the three-state order |
| state_a | output | 1 | High state bit A |
| state_b | output | 1 | Low state bit B |
| in_cycle | output | 1 | 1 when the present state lies on the selected loop |

## Verification
Every one of the four states is driven through all eight combinations of the two enables and the selector. Holding and stepping are therefore separated for each state, and the two orders are distinguished state by state, including the stray 11 under the short loop.

Reset is applied while the enables are high, which shows that reset wins over a step. A scripted walk flips the selector between steps, which shows that the next move always starts from the present state. Inputs are also toggled between edges, which shows that the outputs only move at an edge.

// File: rtl/seq2_pkg.sv
package seq2_pkg;
    localparam int STATE_W = 2;
    typedef logic [STATE_W-1:0] state_t;

    localparam state_t ST_00 = 2'b00;
    localparam state_t ST_01 = 2'b01;
    localparam state_t ST_10 = 2'b10;
    localparam state_t ST_11 = 2'b11;

    typedef struct packed {
        state_t st;
    } seq_regs_t;
endpackage

// File: rtl/seq2_order_logic.sv
// Successor of the present state for the selected order.
module seq2_order_logic
    import seq2_pkg::*;
(
    input  state_t cur_i,
    input  logic   short_i,
    output state_t nxt_o
);
    state_t long_nxt;
    state_t short_nxt;

    // four-code walk: 00 -> 11 -> 10 -> 01 -> 00
    always_comb begin
        unique case (cur_i)
            ST_00:   long_nxt = ST_11;
            ST_11:   long_nxt = ST_10;
            ST_10:   long_nxt = ST_01;
            default: long_nxt = ST_00;
        endcase
    end

    // three-code walk: 00 -> 10 -> 01 -> 00; stray 11 recovers to 00
    always_comb begin
        unique case (cur_i)
            ST_00:   short_nxt = ST_10;
            ST_10:   short_nxt = ST_01;
            ST_01:   short_nxt = ST_00;
            default: short_nxt = ST_00;
        endcase
    end

    assign nxt_o = short_i ? short_nxt : long_nxt;
endmodule

// File: rtl/seq2_member.sv
// Tells whether the present state sits on the selected loop.
module seq2_member
    import seq2_pkg::*;
(
    input  state_t cur_i,
    input  logic   short_i,
    output logic   member_o
);
    always_comb begin
        member_o = 1'b1;
        if (short_i && (cur_i == ST_11)) begin
            member_o = 1'b0;
        end
    end
endmodule

// File: rtl/seq2_stepper.sv
module seq2_stepper
    import seq2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_en_a,
    input  logic step_en_b,
    input  logic order_sel,
    output logic state_a,
    output logic state_b,
    output logic in_cycle
);
    seq_regs_t regs_d;
    seq_regs_t regs_q;
    state_t    succ;
    logic      advance;

    seq2_order_logic u_order (
        .cur_i   (regs_q.st),
        .short_i (order_sel),
        .nxt_o   (succ)
    );

    seq2_member u_member (
        .cur_i    (regs_q.st),
        .short_i  (order_sel),
        .member_o (in_cycle)
    );

    assign advance = step_en_a & step_en_b;

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.st = ST_00;
        end else if (advance) begin
            regs_d.st = succ;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign state_a = regs_q.st[1];
    assign state_b = regs_q.st[0];
endmodule

// File: rtl/seq2_stepper_chk.sv
module seq2_stepper_chk (
    input logic clk,
    input logic rst,
    input logic en_a,
    input logic en_b,
    input logic sel,
    input logic a,
    input logic b,
    input logic flag
);
    logic [1:0] st;
    logic       go;
    assign st = {a, b};
    assign go = en_a & en_b;

    // R1
    reset_to_zero_chk: assert property (@(posedge clk)
        rst |=> (st == 2'b00));

    // R2
    hold_when_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !go |=> $stable(st));

    // R3
    long_from_00_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !sel && st == 2'b00) |=> (st == 2'b11));

    // R3
    long_from_10_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !sel && st == 2'b10) |=> (st == 2'b01));

    // R4
    short_from_00_chk: assert property (@(posedge clk) disable iff (rst)
        (go && sel && st == 2'b00) |=> (st == 2'b10));

    // R4
    short_from_01_chk: assert property (@(posedge clk) disable iff (rst)
        (go && sel && st == 2'b01) |=> (st == 2'b00));

    // R5
    stray_recover_chk: assert property (@(posedge clk) disable iff (rst)
        (go && sel && st == 2'b11) |=> (st == 2'b00));

    // R7
    flag_off_stray_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && st == 2'b11) |-> !flag);

    // R7
    flag_on_long_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |-> flag);
endmodule

bind seq2_stepper seq2_stepper_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .en_a (step_en_a),
    .en_b (step_en_b),
    .sel  (order_sel),
    .a    (state_a),
    .b    (state_b),
    .flag (in_cycle)
);

// File: tb/seq2_stepper_tb.sv
module seq2_stepper_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ea = 1'b0;
    logic eb = 1'b0;
    logic g = 1'b0;
    logic sa, sb, fl;
    int   n_run = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    seq2_stepper dut_i (
        .clk       (clk),
        .rst       (rst),
        .step_en_a (ea),
        .step_en_b (eb),
        .order_sel (g),
        .state_a   (sa),
        .state_b   (sb),
        .in_cycle  (fl)
    );

    // long order is a decrement mod 4; short order is (s+2) mod 3, with 3 -> 0
    function automatic int succ(int s, bit sel);
        if (!sel) return (s + 3) % 4;
        if (s == 3) return 0;
        return (s + 2) % 3;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(bit r, bit a, bit b, bit s);
        @(negedge clk);
        rst = r; ea = a; eb = b; g = s;
        @(posedge clk);
        #1;
    endtask

    task automatic go_to(int s);
        cyc(1, 1, 1, 0);
        for (int k = 0; k < (4 - s) % 4; k++) cyc(0, 1, 1, 0);
    endtask

    initial begin
        int cur;
        // R1: reset state, with stepping enabled to show priority
        cyc(1, 1, 1, 0);
        chk("R1", {sa, sb}, 0);
        cyc(0, 1, 1, 0);
        cyc(1, 1, 1, 1);
        chk("R1 priority", {sa, sb}, 0);

        // exhaustive: every state x every input combination
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 8; c++) begin
                bit a = c[2], b = c[1], sel = c[0];
                int exp;
                go_to(s);
                chk("R3 setup", {sa, sb}, s);
                cyc(0, a, b, sel);
                exp = (a && b) ? succ(s, sel) : s;
                if (!(a && b)) chk("R2", {sa, sb}, exp);
                else if (!sel) chk("R3", {sa, sb}, exp);
                else if (s == 3) chk("R5", {sa, sb}, exp);
                else chk("R4", {sa, sb}, exp);
                chk("R7", fl, (sel && exp == 3) ? 0 : 1);
            end
        end

        // R6: selector flipped between steps
        cyc(1, 0, 0, 0);
        cur = 0;
        begin
            bit pat [8] = '{0, 0, 1, 1, 0, 1, 0, 0};
            for (int i = 0; i < 8; i++) begin
                cyc(0, 1, 1, pat[i]);
                cur = succ(cur, pat[i]);
                chk("R6", {sa, sb}, cur);
            end
        end

        // R8: inputs change between edges, outputs wait for the edge
        cyc(1, 0, 0, 0);
        #5;
        rst = 0; ea = 1; eb = 1; g = 0;
        #8;
        chk("R8 between edges", {sa, sb}, 0);
        @(posedge clk);
        #1;
        chk("R8 at edge", {sa, sb}, 3);

        // R7: flag follows selector combinationally in state 11
        @(negedge clk);
        ea = 0; g = 1;
        #2;
        chk("R7 sel=1 in 11", fl, 0);
        g = 0;
        #2;
        chk("R7 sel=0 in 11", fl, 1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_bad++;
                $display("FAIL watchdog: got 0 expected 1");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule